// File: doc/BRIEF.md
# Sliced 53-Bit Significand Multiplier

This block forms the exact unsigned product of two 53-bit significands. It does not use one wide behavioural multiply. Each operand is cut into a few narrow bit fields, and every field pair that is needed is multiplied on its own. The field widths are chosen so that each of these multiplies fits a small 25x18 signed hardware multiplier when the values are unsigned. Each partial product is shifted to its weight and the shifted terms are summed by a registered binary adder tree. The final 106-bit sum sits in an output register.

The block is fully pipelined. A new operand pair can enter on every clock. An input strobe marks the cycles that carry real operands, and a matching output strobe follows it after a fixed number of cycles. Sign, exponent, normalization and rounding are handled by the surrounding datapath and are not part of this block.

Top module: `sig_tile_mul`

## Requirements
- R1: When `res_valid` is high, `res_prod` equals the exact unsigned product of the two 53-bit operands that were presented with the matching `op_valid`.
- R2: `res_valid` is high in exactly the cycles that follow a cycle with `op_valid` high by 5 clock edges. In every other cycle it is low.
- R3: `rst` is synchronous and active high. On the edge after it is sampled high, `res_valid` is low, and any operand still in flight at that point produces no output strobe.
- R4: The block accepts a new operand pair on every clock. A run of back-to-back operands gives back-to-back correct results in the same order.
- R5: A zero in either operand gives a product of zero.
- R6: If one operand equals 1, the product equals the other operand, zero-extended to 106 bits.
- R7: Two all-ones operands give 2^106 - 2^54 + 1.
- R8: Two normalized significands (bit 52 set in both) give a product with bit 105 or bit 104 set. The minimum normalized value 2^52 squared sets bit 104 only.
- R9: The weights of the slices are placed correctly. For an operand A with only bit i set and an operand B with only bit j set, the product has only bit i+j set. This holds for every i and for every j on either side of each slice boundary. A is split at bits 24 and 41. B is split at bits 17, 34 and 51.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Marks a cycle that carries an operand pair |
| op_a | input | 53 | First unsigned significand |
| op_b | input | 53 | Second unsigned significand |
| res_valid | output | 1 | Marks the cycle that carries a result |
| res_prod | output | 106 | Registered unsigned product |

## Verification
The bench builds the block with its default values: ten slice multipliers feeding a four-level adder tree, which gives a latency of 5. With these values a single-bit sweep reaches every slice boundary of both operands. The all-ones case drives every partial product to its maximum value, so the carry chain is exercised at each tree level. Random operands with random gaps in the strobe, a burst of back-to-back pairs and a reset in the middle of a run cover the timing of the strobe and the order of the results.

// File: rtl/sigmul_pkg.sv
package sigmul_pkg;

  localparam int unsigned SIG_W      = 53;
  localparam int unsigned TILE_COUNT = 10;

  // Low bit of the A field used by tile k
  function automatic int unsigned tile_a_lo(int unsigned k);
    if (k < 4)      return 0;
    else if (k < 7) return 24;
    else            return 41;
  endfunction

  // Width of the A field used by tile k
  function automatic int unsigned tile_a_w(int unsigned k);
    if (k < 4)      return 24;
    else if (k < 7) return 17;
    else            return 12;
  endfunction

  // Low bit of the B field used by tile k
  function automatic int unsigned tile_b_lo(int unsigned k);
    case (k)
      0, 4, 7: return 0;
      1, 5, 8: return 17;
      2, 6, 9: return 34;
      default: return 51;
    endcase
  endfunction

  // Width of the B field used by tile k
  function automatic int unsigned tile_b_w(int unsigned k);
    case (k)
      3:       return 2;
      6, 9:    return 19;
      default: return 17;
    endcase
  endfunction

endpackage

// File: rtl/sigmul_tile.sv
module sigmul_tile #(
  parameter int unsigned A_W    = 24,
  parameter int unsigned B_W    = 17,
  parameter int unsigned OFF    = 0,
  parameter int unsigned PROD_W = 106
) (
  input  logic              clk,
  input  logic [A_W-1:0]    a_part,
  input  logic [B_W-1:0]    b_part,
  output logic [PROD_W-1:0] term
);

  localparam int unsigned PP_W = A_W + B_W;

  logic [PP_W-1:0] pp;

  always_comb pp = PP_W'(a_part) * PP_W'(b_part);

  always_ff @(posedge clk) begin
    term <= PROD_W'(pp) << OFF;
  end

endmodule

// File: rtl/sigmul_add_tree.sv
module sigmul_add_tree #(
  parameter int unsigned N_IN = 10,
  parameter int unsigned W    = 106
) (
  input  logic                     clk,
  input  logic [N_IN-1:0][W-1:0]   terms,
  output logic [W-1:0]             sum
);

  localparam int unsigned LVLS = $clog2(N_IN);

  function automatic int unsigned lvl_cnt(int unsigned n, int unsigned l);
    int unsigned c;
    c = n;
    for (int unsigned i = 0; i < l; i++) c = (c + 1) / 2;
    return c;
  endfunction

  for (genvar l = 0; l <= LVLS; l++) begin : lvl
    localparam int unsigned CNT  = lvl_cnt(N_IN, l);
    localparam int unsigned PCNT = (l == 0) ? N_IN : lvl_cnt(N_IN, l - 1);
    for (genvar j = 0; j < CNT; j++) begin : nd
      logic [W-1:0] q;
      if (l == 0) begin : g_leaf
        always_comb q = terms[j];
      end else if (2 * j + 1 < PCNT) begin : g_add
        always_ff @(posedge clk) q <= lvl[l-1].nd[2*j].q + lvl[l-1].nd[2*j+1].q;
      end else begin : g_pass
        always_ff @(posedge clk) q <= lvl[l-1].nd[2*j].q;
      end
    end
  end

  assign sum = lvl[LVLS].nd[0].q;

endmodule

// File: rtl/sig_tile_mul.sv
module sig_tile_mul
  import sigmul_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  logic [SIG_W-1:0]     op_a,
  input  logic [SIG_W-1:0]     op_b,
  output logic                 res_valid,
  output logic [2*SIG_W-1:0]   res_prod
);

  localparam int unsigned PROD_W    = 2 * SIG_W;
  localparam int unsigned TREE_LVLS = $clog2(TILE_COUNT);
  localparam int unsigned LATENCY   = 1 + TREE_LVLS;

  logic [TILE_COUNT-1:0][PROD_W-1:0] terms;
  logic [LATENCY-1:0]                vpipe;

  for (genvar k = 0; k < TILE_COUNT; k++) begin : g_tile
    localparam int unsigned ALO = tile_a_lo(k);
    localparam int unsigned AW  = tile_a_w(k);
    localparam int unsigned BLO = tile_b_lo(k);
    localparam int unsigned BW  = tile_b_w(k);
    sigmul_tile #(
      .A_W   (AW),
      .B_W   (BW),
      .OFF   (ALO + BLO),
      .PROD_W(PROD_W)
    ) u_tile (
      .clk   (clk),
      .a_part(op_a[ALO +: AW]),
      .b_part(op_b[BLO +: BW]),
      .term  (terms[k])
    );
  end

  sigmul_add_tree #(
    .N_IN(TILE_COUNT),
    .W   (PROD_W)
  ) u_tree (
    .clk  (clk),
    .terms(terms),
    .sum  (res_prod)
  );

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LATENCY-2:0], op_valid};
  end

  assign res_valid = vpipe[LATENCY-1];

endmodule

// File: rtl/sig_tile_mul_chk.sv
module sig_tile_mul_chk #(
  parameter int unsigned SIG_W = 53,
  parameter int unsigned LAT   = 5
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 op_valid,
  input logic [SIG_W-1:0]     op_a,
  input logic [SIG_W-1:0]     op_b,
  input logic                 res_valid,
  input logic [2*SIG_W-1:0]   res_prod
);

  localparam int unsigned PROD_W = 2 * SIG_W;
  localparam logic [PROD_W-1:0] ONES_SQ =
    {PROD_W{1'b1}} - (PROD_W'(1) << (SIG_W + 1)) + PROD_W'(2);

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> ##LAT res_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(op_valid, LAT));

  assert_reset_clears_R3: assert property (@(posedge clk)
    rst |=> !res_valid);

  assert_zero_operand_R5: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past((op_a == '0) || (op_b == '0), LAT)) |-> (res_prod == '0));

  assert_unit_operand_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(op_a == SIG_W'(1), LAT)) |-> (res_prod == PROD_W'($past(op_b, LAT))));

  assert_all_ones_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past((&op_a) && (&op_b), LAT)) |-> (res_prod == ONES_SQ));

  assert_normalized_top_R8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(op_a[SIG_W-1] && op_b[SIG_W-1], LAT))
      |-> (res_prod[PROD_W-1] || res_prod[PROD_W-2]));

  assert_single_bit_R9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past($onehot(op_a) && $onehot(op_b), LAT)) |-> $onehot(res_prod));

endmodule

bind sig_tile_mul sig_tile_mul_chk #(
  .SIG_W(sigmul_pkg::SIG_W),
  .LAT  (LATENCY)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_a     (op_a),
  .op_b     (op_b),
  .res_valid(res_valid),
  .res_prod (res_prod)
);

// File: tb/sig_tile_mul_bench.sv
module sig_tile_mul_bench;

  localparam int W   = 53;
  localparam int PW  = 106;
  localparam int LAT = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic          res_valid;
  logic [PW-1:0] res_prod;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  string cur_tag = "R1";

  bit            mv [LAT];
  logic [PW-1:0] mp [LAT];
  string         mt [LAT];

  sig_tile_mul u_sig_tile_mul (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .res_valid(res_valid),
    .res_prod (res_prod)
  );

  always #5 clk = ~clk;

  // Behavioural reference: plain wide multiply moved through a LAT-deep queue
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LAT; i++) begin mv[i] = 1'b0; mp[i] = '0; mt[i] = ""; end
    end else begin
      for (int i = LAT - 1; i > 0; i--) begin mv[i] = mv[i-1]; mp[i] = mp[i-1]; mt[i] = mt[i-1]; end
      mv[0] = op_valid;
      mp[0] = {{(PW-W){1'b0}}, op_a} * {{(PW-W){1'b0}}, op_b};
      mt[0] = cur_tag;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (res_valid !== mv[LAT-1]) begin
        errors++;
        $display("FAIL R2 valid timing: actual %b expected %b", res_valid, mv[LAT-1]);
      end else if (mv[LAT-1]) begin
        checks++;
        if (res_prod !== mp[LAT-1]) begin
          errors++;
          $display("FAIL %s product: actual %h expected %h", mt[LAT-1], res_prod, mp[LAT-1]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R2 watchdog expired: actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [W-1:0] rnd53();
    return W'({$urandom, $urandom});
  endfunction

  task automatic put(input logic [W-1:0] a, input logic [W-1:0] b, input bit v, input string tag);
    @(negedge clk);
    op_a = a; op_b = b; op_valid = v; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) put(rnd53(), rnd53(), 1'b0, "R2");
  endtask

  initial begin
    int bpos [12] = '{0, 16, 17, 23, 24, 33, 34, 40, 41, 50, 51, 52};
    repeat (3) @(negedge clk);
    // R3: output strobe low while reset holds
    checks++;
    if (res_valid !== 1'b0) begin
      errors++; $display("FAIL R3 reset state: actual %b expected 0", res_valid);
    end
    rst = 1'b0;

    // R1: random operands with random gaps
    for (int i = 0; i < 300; i++) put(rnd53(), rnd53(), ($urandom % 3) != 0, "R1");
    idle(LAT + 1);

    // R4: back-to-back burst
    for (int i = 0; i < 64; i++) put(rnd53() | (W'(1) << (W-1)), rnd53(), 1'b1, "R4");
    idle(LAT + 1);

    // R5: zero operands
    put('0, rnd53(), 1'b1, "R5");
    put(rnd53(), '0, 1'b1, "R5");
    put('0, '0, 1'b1, "R5");
    // R6: unit operand
    put(W'(1), rnd53(), 1'b1, "R6");
    put(rnd53(), W'(1), 1'b1, "R6");
    // R7: all ones
    put('1, '1, 1'b1, "R7");
    // R8: normalized bounds
    put(W'(1) << (W-1), W'(1) << (W-1), 1'b1, "R8");
    put('1, W'(1) << (W-1), 1'b1, "R8");
    for (int i = 0; i < 20; i++)
      put(rnd53() | (W'(1) << (W-1)), rnd53() | (W'(1) << (W-1)), 1'b1, "R8");
    idle(LAT + 1);

    // R9: single-bit sweep across slice boundaries of both operands
    for (int i = 0; i < W; i++)
      for (int j = 0; j < 12; j++) begin
        put(W'(1) << i, W'(1) << bpos[j], 1'b1, "R9");
        put(W'(1) << bpos[j], W'(1) << i, 1'b1, "R9");
      end
    idle(LAT + 1);

    // R3: reset in mid-run drops operands in flight
    for (int i = 0; i < 3; i++) put(rnd53(), rnd53(), 1'b1, "R3");
    @(negedge clk);
    op_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0) begin
      errors++; $display("FAIL R3 mid-run reset: actual %b expected 0", res_valid);
    end
    rst = 1'b0;
    idle(LAT + 2);
    put('1, rnd53(), 1'b1, "R1");
    idle(LAT + 2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule